// File: doc/BRIEF.md
# Execute-I/O Cycle and Adapter Timing Sequencer

This block tracks an execute-I/O instruction as it moves through its execute cycles, and it paces the device adapters. When an instruction starts, the block raises a control-cycle flag for the first execute cycle. During that cycle it latches a 3-bit command code and decodes it into one of seven command lines. It then raises a data-cycle flag in the execute cycle where the data word moves. That is the second execute cycle for most commands, and the third for read and write, because those spend their second cycle fetching an address word.

The block also drives three adapter timing pulses, A, B and C. Each pulse is an overlapping window across the eight-phase machine cycle, built from set and reset conditions.

Each step of the cycle arrives as a registered phase number with a valid strobe. The phase number can come from the processor clock or from the channel clock; both use the same 0 to 7 numbering. A cycle of the clock with the strobe low is a stopped clock, and nothing moves. Every output is a register that updates on the clock edge where a valid phase is presented. Reset is asynchronous and active low.

Top module: `xio_cycle_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no valid phase yet applied, all of the following are 0: `fn_lines`, `ctl_cyc`, `dat_cyc`, `tp_a`, `tp_b` and `tp_c`.
- R2: A phase-0 step with `xio_start` and `e1_cyc` both high sets `ctl_cyc`. The next phase-7 step clears it.
- R3: A phase-5 step while `ctl_cyc` is high latches `code_bits` and decodes it:
  - code n (1 to 7) drives only `fn_lines[n-1]`;
  - code 0 drives no line;
  - code 1 is write and code 2 is read.
  `code_bits` presented at any other step has no effect on `fn_lines`.
- R4: The phase-7 step that ends the data cycle clears `fn_lines` to 0.
- R5: For a command other than read or write, a phase-0 step with `e2_cyc` high after the control cycle sets `dat_cyc`. A phase-7 step clears it.
- R6: For read or write, `e2_cyc` does not start the data cycle. A phase-0 step with `e3_cyc` high sets `dat_cyc`, and a phase-7 step clears it.
- R7: `tp_a` is set by the phase-1 step and cleared by the phase-5 step. It is therefore high after the steps for phases 1 to 4.
- R8: `tp_b` sets on a phase-1 or phase-3 step only while `tp_a` is high. It clears on a phase-5 or phase-7 step only while `tp_a` is low. It is therefore high after the steps for phases 3 to 6.
- R9: `tp_c` turns on at phase-0 and phase-4 steps and off at phase-2 and phase-6 steps.
- R10: A clock cycle with `ph_valid` low changes no output, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ph_valid | input | 1 | A phase step is presented this cycle |
| ph_num | input | 3 | Phase number 0 to 7 of the running clock |
| e1_cyc | input | 1 | First execute cycle in progress |
| e2_cyc | input | 1 | Second execute cycle in progress |
| e3_cyc | input | 1 | Third execute cycle in progress |
| xio_start | input | 1 | Execute-I/O instruction begins |
| code_bits | input | 3 | Command code bits from the channel data bus |
| fn_lines | output | 7 | One-hot decoded command lines |
| ctl_cyc | output | 1 | Control-cycle flag |
| dat_cyc | output | 1 | Data-cycle flag |
| tp_a | output | 1 | Adapter timing pulse A |
| tp_b | output | 1 | Adapter timing pulse B |
| tp_c | output | 1 | Adapter timing pulse C |

## Verification
The phase-7 step that ends a data cycle does three things on one edge: it drops `dat_cyc`, it clears the command lines, and it drops `tp_b`. The phase-0 step that follows can start the next instruction in the same edge that raises `tp_c`. The bench runs instructions back to back to provoke both collisions. Its scoreboard item for that edge holds the expected value of every output, so a term missing from either function shows up on the field that should have changed.

// File: rtl/xio_seq_pkg.sv
package xio_seq_pkg;
  localparam int PH_W   = 3;
  localparam int NUM_PH = 1 << PH_W;
  localparam int FN_W   = 3;
  localparam int NUM_FN = (1 << FN_W) - 1;

  localparam logic [FN_W-1:0] FN_WRITE = 3'd1;
  localparam logic [FN_W-1:0] FN_READ  = 3'd2;

  localparam int PULSES = 3;

  // Code n (1..NUM_FN) drives line n-1; code 0 drives no line.
  function automatic logic [NUM_FN-1:0] fn_decode(input logic [FN_W-1:0] code);
    logic [NUM_FN-1:0] v;
    v = '0;
    for (int i = 1; i <= NUM_FN; i++)
      if (code == FN_W'(i)) v[i-1] = 1'b1;
    return v;
  endfunction

  function automatic logic fn_lines_rw(input logic [NUM_FN-1:0] lines);
    return lines[int'(FN_WRITE)-1] | lines[int'(FN_READ)-1];
  endfunction

  // Pulse index: 0 = A, 1 = B, 2 = C.
  function automatic logic [NUM_PH-1:0] pulse_set_mask(input int k);
    return (k == 2) ? 8'b0001_0001 : 8'b0000_1010;
  endfunction

  function automatic logic [NUM_PH-1:0] pulse_clr_mask(input int k);
    return (k == 2) ? 8'b0100_0100 : 8'b1010_0000;
  endfunction

  function automatic logic pulse_gated(input int k);
    return k == 1;
  endfunction
endpackage

// File: rtl/xio_fn_reg.sv
module xio_fn_reg
  import xio_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              clr_en,
  input  logic [FN_W-1:0]   code_in,
  output logic [NUM_FN-1:0] lines_q,
  output logic              rw_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lines_q <= '0;
    else if (cap_en) lines_q <= fn_decode(code_in);
    else if (clr_en) lines_q <= '0;
  end

  assign rw_sel = fn_lines_rw(lines_q);
endmodule

// File: rtl/xio_cycle_flags.sv
module xio_cycle_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic step_ph0,
  input  logic step_ph7,
  input  logic e1_cyc,
  input  logic e2_cyc,
  input  logic e3_cyc,
  input  logic xio_start,
  input  logic rw_sel,
  output logic ctl_q,
  output logic dat_q,
  output logic end_data
);
  logic busy_q;
  logic begin_xio;
  logic begin_data;

  assign begin_xio  = step_ph0 & e1_cyc & xio_start;
  assign begin_data = step_ph0 & busy_q & ~ctl_q & (rw_sel ? e3_cyc : e2_cyc);
  assign end_data   = step_ph7 & dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= 1'b0;
      dat_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (begin_xio)     ctl_q <= 1'b1;
      else if (step_ph7) ctl_q <= 1'b0;

      if (begin_data)    dat_q <= 1'b1;
      else if (step_ph7) dat_q <= 1'b0;

      if (begin_xio)     busy_q <= 1'b1;
      else if (end_data) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/xio_pulse_bit.sv
module xio_pulse_bit
  import xio_seq_pkg::*;
#(
  parameter int KIND = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] ph_hit,
  input  logic              a_now,
  output logic              q
);
  localparam logic [NUM_PH-1:0] SET_M = pulse_set_mask(KIND);
  localparam logic [NUM_PH-1:0] CLR_M = pulse_clr_mask(KIND);
  localparam bit                GATED = pulse_gated(KIND);

  logic set_hit, clr_hit;

  assign set_hit = (|(ph_hit & SET_M)) & (GATED ? a_now  : 1'b1);
  assign clr_hit = (|(ph_hit & CLR_M)) & (GATED ? ~a_now : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (set_hit) q <= 1'b1;
    else if (clr_hit) q <= 1'b0;
  end
endmodule

// File: rtl/xio_cycle_seq.sv
module xio_cycle_seq
  import xio_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph_valid,
  input  logic [PH_W-1:0]   ph_num,
  input  logic              e1_cyc,
  input  logic              e2_cyc,
  input  logic              e3_cyc,
  input  logic              xio_start,
  input  logic [FN_W-1:0]   code_bits,
  output logic [NUM_FN-1:0] fn_lines,
  output logic              ctl_cyc,
  output logic              dat_cyc,
  output logic              tp_a,
  output logic              tp_b,
  output logic              tp_c
);
  logic [NUM_PH-1:0] ph_hit;
  logic              rw_sel;
  logic              end_data;
  logic              cap_en;
  logic [PULSES-1:0] tp_q;

  always_comb begin
    ph_hit = '0;
    if (ph_valid) ph_hit[ph_num] = 1'b1;
  end

  assign cap_en = ph_hit[5] & ctl_cyc;

  xio_fn_reg u_fn (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .clr_en  (end_data),
    .code_in (code_bits),
    .lines_q (fn_lines),
    .rw_sel  (rw_sel)
  );

  xio_cycle_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_ph0  (ph_hit[0]),
    .step_ph7  (ph_hit[NUM_PH-1]),
    .e1_cyc    (e1_cyc),
    .e2_cyc    (e2_cyc),
    .e3_cyc    (e3_cyc),
    .xio_start (xio_start),
    .rw_sel    (rw_sel),
    .ctl_q     (ctl_cyc),
    .dat_q     (dat_cyc),
    .end_data  (end_data)
  );

  for (genvar g = 0; g < PULSES; g++) begin : g_tp
    xio_pulse_bit #(.KIND(g)) u_tp (
      .clk    (clk),
      .rst_n  (rst_n),
      .ph_hit (ph_hit),
      .a_now  (tp_q[0]),
      .q      (tp_q[g])
    );
  end

  assign tp_a = tp_q[0];
  assign tp_b = tp_q[1];
  assign tp_c = tp_q[2];
endmodule

// File: rtl/xio_cycle_seq_chk.sv
module xio_cycle_seq_chk
  import xio_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ph_valid,
  input logic [PH_W-1:0]   ph_num,
  input logic [NUM_FN-1:0] fn_lines,
  input logic              ctl_cyc,
  input logic              dat_cyc,
  input logic              tp_a,
  input logic              tp_b,
  input logic              tp_c
);
  AST_FN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fn_lines)); // R3
  AST_CTL_DAT_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_cyc && dat_cyc)); // R5
  AST_CTL_DROP_PH7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && ph_num == 3'd7) |=> !ctl_cyc); // R2
  AST_A_OFF_PH5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && ph_num == 3'd5) |=> !tp_a); // R7
  AST_B_NEEDS_A: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tp_b) |-> $past(tp_a)); // R8
  AST_C_ON_PH0: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && ph_num == 3'd0) |=> tp_c); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_valid |=> $stable({fn_lines, ctl_cyc, dat_cyc, tp_a, tp_b, tp_c})); // R10
endmodule

bind xio_cycle_seq xio_cycle_seq_chk u_chk (.*);

// File: tb/tb_xio_cycle_seq.sv
module tb_xio_cycle_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ph_valid = 1'b0;
  logic [2:0] ph_num = '0;
  logic       e1_cyc = 1'b0, e2_cyc = 1'b0, e3_cyc = 1'b0, xio_start = 1'b0;
  logic [2:0] code_bits = '0;
  logic [6:0] fn_lines;
  logic       ctl_cyc, dat_cyc, tp_a, tp_b, tp_c;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  xio_cycle_seq dut (.*);

  typedef struct {
    logic [6:0] fn;
    logic ctl, dat, a, b, c;
    bit   idle, rw, ended;
  } exp_t;

  exp_t sb_q[$];

  // Reference state, restated from the requirements.
  int m_code = 0;
  bit m_ctl = 0, m_dat = 0, m_busy = 0, m_a = 0, m_b = 0, m_c = 0;

  task automatic chk1(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expectations half a cycle after each edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (fn_lines !== e.fn) begin
        n_fail++;
        $display("FAIL %s fn_lines: got %b expected %b",
                 e.idle ? "R10" : (e.ended ? "R4" : "R3"), fn_lines, e.fn);
      end
      chk1(e.idle ? "R10" : "R2", "ctl_cyc", ctl_cyc, e.ctl);
      chk1(e.idle ? "R10" : (e.rw ? "R6" : "R5"), "dat_cyc", dat_cyc, e.dat);
      chk1(e.idle ? "R10" : "R7", "tp_a", tp_a, e.a);
      chk1(e.idle ? "R10" : "R8", "tp_b", tp_b, e.b);
      chk1(e.idle ? "R10" : "R9", "tp_c", tp_c, e.c);
    end
  end

  // Driver: one clock cycle, then the expected result goes to the queue.
  task automatic step(input bit v, input int p, input bit s1, input bit s2,
                      input bit s3, input bit st, input int code);
    exp_t e;
    bit rw, ended;
    @(negedge clk);
    ph_valid = v; ph_num = 3'(p); e1_cyc = s1; e2_cyc = s2; e3_cyc = s3;
    xio_start = st; code_bits = 3'(code);
    rw = (m_code == 1) || (m_code == 2);
    ended = 0;
    if (v) begin
      bit o_ctl, o_dat, o_busy;
      o_ctl = m_ctl; o_dat = m_dat; o_busy = m_busy;
      ended = (p == 7) && o_dat;
      if (p == 0 && s1 && st) m_ctl = 1; else if (p == 7) m_ctl = 0;
      if (p == 0 && s1 && st) m_busy = 1; else if (ended) m_busy = 0;
      if (p == 5 && o_ctl) m_code = code; else if (ended) m_code = 0;
      if (p == 0 && o_busy && !o_ctl && (rw ? s3 : s2)) m_dat = 1;
      else if (p == 7) m_dat = 0;
      m_a = (p >= 1 && p <= 4);
      m_b = (p >= 3 && p <= 6);
      m_c = (p == 0 || p == 1 || p == 4 || p == 5);
    end
    e.fn = (m_code == 0) ? 7'd0 : 7'(1 << (m_code - 1));
    e.ctl = m_ctl; e.dat = m_dat; e.a = m_a; e.b = m_b; e.c = m_c;
    e.idle = !v; e.rw = rw; e.ended = ended;
    @(posedge clk);
    #1 sb_q.push_back(e);
  endtask

  // One machine cycle of eight phases; stray code values away from phase 5.
  task automatic run_cycle(input bit s1, input bit s2, input bit s3, input bit st,
                           input int code, input bit gaps);
    for (int p = 0; p < 8; p++) begin
      step(1, p, s1, s2, s3, (p == 0) && st, (p == 5) ? code : (7 - code));
      if (gaps && (p == 2 || p == 7))
        step(0, (p + 3) % 8, ~s1, ~s2, ~s3, 1, p);
    end
  endtask

  task automatic run_xio(input int code, input bit gaps);
    run_cycle(1, 0, 0, 1, code, gaps);
    run_cycle(0, 1, 0, 0, code, gaps);
    run_cycle(0, 0, 1, 0, code, gaps);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #12;
    chk1("R1", "ctl_cyc in reset", ctl_cyc, 1'b0);
    chk1("R1", "tp_c in reset", tp_c, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if ({fn_lines, ctl_cyc, dat_cyc, tp_a, tp_b, tp_c} !== 12'd0) begin
      n_fail++;
      $display("FAIL R1 outputs after reset: got %h expected 0",
               {fn_lines, ctl_cyc, dat_cyc, tp_a, tp_b, tp_c});
    end
    run_cycle(0, 0, 0, 0, 4, 0);   // R7 R8 R9 idle pulses
    run_xio(3, 0);                 // R5 non-rw command
    run_xio(2, 0);                 // R6 read
    run_xio(1, 1);                 // R6 write with stopped-clock gaps, R10
    run_xio(7, 1);                 // R3 top code
    run_xio(0, 0);                 // R3 code 0 drives no line
    run_xio(5, 0);                 // R4 back to back
    run_cycle(0, 1, 1, 1, 6, 0);   // start without e1 is no instruction
    run_cycle(0, 0, 0, 0, 6, 1);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule